// File: doc/BRIEF.md
# Serial Bus Hand-Over Sequencer for Data-to-Control Mode Entry

This block takes over the four serial bus pins of a codec-style device at the moment an external controller pulls the mode pin low to demand control mode. The pins are frame sync, serial clock, serial data out and time-slot out. While the device is in data mode, the block passes the drive values and output enables that the data-mode logic supplies, through one register stage. When the mode pin goes low, the block releases each pin on its own schedule, so that bus ownership moves cleanly to the controller.

Two inputs select the release schedule. One is whether the device was the bus master in the data mode just left. The other is the time-slot control bit. Both come from a configuration register held inside the block, and both are captured at the moment the low-going edge is recognised. The mode pin may change at any time relative to the internal clock, so it passes through a synchroniser before edge detection. On entry to control mode, the configuration register is reloaded with its default value, and that value sets the mute bit. One internal clock cycle stands for one serial clock period.

Top module: `bos_mode_switch`

## Requirements
- R1: The mode pin `dc_i` (1 = data mode, 0 = control mode) passes through two synchroniser flops. If `dc_i` falls just before clock edge n, `ctrl_o` rises after edge n+2, and the pins show the first control-mode period (k=0) after edge n+3. Each later edge advances k by one.
- R2: In data mode, each pin's drive value and enable equal the matching `dm_*` inputs sampled one clock edge earlier.
- R3: If the device was master with slot bit 0, frame sync is driven low (`fs_oe`=1, `fs_d`=0) for period k=0 and is released from k=1 onward. Serial data out is released from k=0.
- R4: If the device was master with slot bit 0, the serial clock pin carries `dm_sclk_d` with `sclk_oe`=1 for periods k=0,1,2, and is released from k=3 onward.
- R5: If the device was master with slot bit 1, frame sync, serial clock and serial data out are all released from k=0.
- R6: If the device was a slave with slot bit 0, serial data out is driven low for period k=0 and released from k=1. Frame sync and serial clock are never driven.
- R7: If the device was a slave with slot bit 1, serial data out, frame sync and serial clock are all released from k=0.
- R8: In control mode, time-slot out is always driven low (`tso_oe`=1, `tso_d`=0). A released pin shows `*_oe`=0 and `*_d`=0.
- R9: On the edge that enters control mode, `cfg_q` is reloaded with `CFG_DEFAULT` (16'h0001, whose bit 0 is the mute bit, shown on `mute_o`). A write on that same edge is lost. Writes on any other edge load `cfg_wdata`.
- R10: The master flag (`cfg_q` bit 14) and the slot bit (`cfg_q` bit 15) are captured on the entry edge. Later writes to `cfg_q` do not change the release schedule that is running.
- R11: While `rst` is high, every pin output and enable is 0, `ctrl_o` is 0, and `cfg_q` equals `CFG_DEFAULT`.
- R12: When `dc_i` rises, `ctrl_o` falls after the third edge, and data-mode pass-through resumes after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; one cycle is one serial period |
| rst | input | 1 | Synchronous active-high reset |
| dc_i | input | 1 | Asynchronous mode pin, 1 = data mode, 0 = control mode |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| dm_fs_d | input | 1 | Data-mode frame sync value |
| dm_fs_oe | input | 1 | Data-mode frame sync enable |
| dm_sclk_d | input | 1 | Data-mode serial clock value |
| dm_sclk_oe | input | 1 | Data-mode serial clock enable |
| dm_sdo_d | input | 1 | Data-mode serial data value |
| dm_sdo_oe | input | 1 | Data-mode serial data enable |
| dm_tso_d | input | 1 | Data-mode time-slot out value |
| dm_tso_oe | input | 1 | Data-mode time-slot out enable |
| fs_d | output | 1 | Frame sync pin value |
| fs_oe | output | 1 | Frame sync pin enable |
| sclk_d | output | 1 | Serial clock pin value |
| sclk_oe | output | 1 | Serial clock pin enable |
| sdo_d | output | 1 | Serial data out pin value |
| sdo_oe | output | 1 | Serial data out pin enable |
| tso_d | output | 1 | Time-slot out pin value |
| tso_oe | output | 1 | Time-slot out pin enable |
| cfg_q | output | 16 | Configuration register contents |
| mute_o | output | 1 | Mute bit of the configuration register |
| ctrl_o | output | 1 | High while in control mode |

## Verification
Each of the four combinations of master flag and slot bit is entered from data mode with every data-mode input held at 1. Any pin the block fails to release then shows up as a stray 1 on its value or enable at the period where the schedules differ (k=0, 1 or 3). Pass-through is tried with two opposing bit patterns, which separates a correct pass-through from a swapped or stuck pin. A write landing on the entry edge shows that the default reload has priority. A write of the opposite slot and master bits in the middle of a schedule shows that the captured values stay in force.

// File: rtl/bos_pkg.sv
package bos_pkg;
  // drive value and output enable of one bus pin
  typedef struct packed {
    logic d;
    logic oe;
  } pin_t;

  // schedule selector: {was_slave, slot_bit}
  typedef enum logic [1:0] {
    OWN_MS0 = 2'b00,
    OWN_MS1 = 2'b01,
    OWN_SL0 = 2'b10,
    OWN_SL1 = 2'b11
  } own_case_e;
endpackage

// File: rtl/bos_sync.sv
module bos_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

  initial begin
    if (STAGES < 2) $error("bos_sync: STAGES must be at least 2");
  end
endmodule

// File: rtl/bos_seq.sv
module bos_seq
  import bos_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dc_sync_i,
  input  logic             master_i,
  input  logic             slot_i,
  output logic             enter_o,
  output logic             ctrl_o,
  output own_case_e        case_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             dc_prev_q, ctrl_q, leave;
  own_case_e        case_q;
  logic [CNT_W-1:0] cnt_q;

  assign enter_o = dc_prev_q & ~dc_sync_i;
  assign leave   = ~dc_prev_q & dc_sync_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dc_prev_q <= 1'b1;
      ctrl_q    <= 1'b0;
      case_q    <= OWN_MS0;
      cnt_q     <= '0;
    end else begin
      dc_prev_q <= dc_sync_i;
      if (enter_o) begin
        ctrl_q <= 1'b1;
        cnt_q  <= '0;
        case_q <= own_case_e'({~master_i, slot_i});
      end else if (leave) begin
        ctrl_q <= 1'b0;
      end else if (ctrl_q && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign case_o = case_q;
  assign cnt_o  = cnt_q;

  // R1: a detected fall opens control mode at period zero
  p_enter_r1: assert property (@(posedge clk) disable iff (rst)
    enter_o |=> (ctrl_q && cnt_q == '0));
  // R10: captured schedule stays fixed while in control mode
  p_case_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q && !enter_o) |=> $stable(case_q));
  // R4: period counter saturates instead of wrapping
  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q && cnt_q == CNT_MAX && !leave) |=> (cnt_q == CNT_MAX));
  // R12: a rise leaves control mode
  p_leave_r12: assert property (@(posedge clk) disable iff (rst)
    leave |=> !ctrl_q);
endmodule

// File: rtl/bos_pins.sv
module bos_pins
  import bos_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int FS_HOLD   = 1,
  parameter int SCLK_HOLD = 3,
  parameter int SDO_HOLD  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_i,
  input  own_case_e        case_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  pin_t             dm_fs_i,
  input  pin_t             dm_sclk_i,
  input  pin_t             dm_sdo_i,
  input  pin_t             dm_tso_i,
  output pin_t             fs_o,
  output pin_t             sclk_o,
  output pin_t             sdo_o,
  output pin_t             tso_o
);
  localparam logic [CNT_W-1:0] FS_LIM   = CNT_W'(FS_HOLD);
  localparam logic [CNT_W-1:0] SCLK_LIM = CNT_W'(SCLK_HOLD);
  localparam logic [CNT_W-1:0] SDO_LIM  = CNT_W'(SDO_HOLD);
  localparam pin_t RELEASED = '{d: 1'b0, oe: 1'b0};
  localparam pin_t LOW      = '{d: 1'b0, oe: 1'b1};

  pin_t fs_n, sclk_n, sdo_n, tso_n;
  pin_t fs_q, sclk_q, sdo_q, tso_q;

  always_comb begin
    if (!ctrl_i) begin
      fs_n   = dm_fs_i;
      sclk_n = dm_sclk_i;
      sdo_n  = dm_sdo_i;
      tso_n  = dm_tso_i;
    end else begin
      fs_n   = RELEASED;
      sclk_n = RELEASED;
      sdo_n  = RELEASED;
      tso_n  = LOW;
      unique case (case_i)
        OWN_MS0: begin
          if (cnt_i < FS_LIM)   fs_n   = LOW;
          if (cnt_i < SCLK_LIM) sclk_n = '{d: dm_sclk_i.d, oe: 1'b1};
        end
        OWN_SL0: begin
          if (cnt_i < SDO_LIM)  sdo_n  = LOW;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= RELEASED;
      sclk_q <= RELEASED;
      sdo_q  <= RELEASED;
      tso_q  <= RELEASED;
    end else begin
      fs_q   <= fs_n;
      sclk_q <= sclk_n;
      sdo_q  <= sdo_n;
      tso_q  <= tso_n;
    end
  end

  assign fs_o   = fs_q;
  assign sclk_o = sclk_q;
  assign sdo_o  = sdo_q;
  assign tso_o  = tso_q;

  // R8: time-slot out held low in every control schedule
  p_tso_low_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl_i |=> (tso_q.oe && !tso_q.d));
  // R3: frame sync released after its hold period
  p_fs_release_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i && cnt_i >= FS_LIM) |=> !fs_q.oe);
  // R5: master with slot bit set releases all three at once
  p_ms1_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i && case_i == OWN_MS1) |=> (!fs_q.oe && !sclk_q.oe && !sdo_q.oe));
  // R6: a former slave never drives clock or frame sync
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i && case_i[1]) |=> (!fs_q.oe && !sclk_q.oe));
  // R2: data mode pass-through, one register stage
  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_i |=> (sdo_q == $past(dm_sdo_i) && tso_q == $past(dm_tso_i)));
endmodule

// File: rtl/bos_mode_switch.sv
module bos_mode_switch
  import bos_pkg::*;
#(
  parameter int              CFG_W       = 16,
  parameter int              MUTE_BIT    = 0,
  parameter int              MST_BIT     = 14,
  parameter int              SLOT_BIT    = 15,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 16'h0001,
  parameter int              SYNC_STAGES = 2,
  parameter int              CNT_W       = 3,
  parameter int              FS_HOLD     = 1,
  parameter int              SCLK_HOLD   = 3,
  parameter int              SDO_HOLD    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dc_i,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             dm_fs_d,
  input  logic             dm_fs_oe,
  input  logic             dm_sclk_d,
  input  logic             dm_sclk_oe,
  input  logic             dm_sdo_d,
  input  logic             dm_sdo_oe,
  input  logic             dm_tso_d,
  input  logic             dm_tso_oe,
  output logic             fs_d,
  output logic             fs_oe,
  output logic             sclk_d,
  output logic             sclk_oe,
  output logic             sdo_d,
  output logic             sdo_oe,
  output logic             tso_d,
  output logic             tso_oe,
  output logic [CFG_W-1:0] cfg_q,
  output logic             mute_o,
  output logic             ctrl_o
);
  logic             dc_sync, enter;
  own_case_e        own_case;
  logic [CNT_W-1:0] cnt;
  logic [CFG_W-1:0] cfg_r;
  pin_t             fs_p, sclk_p, sdo_p, tso_p;

  bos_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .async_i(dc_i), .sync_o(dc_sync)
  );

  bos_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .dc_sync_i(dc_sync),
    .master_i(cfg_r[MST_BIT]), .slot_i(cfg_r[SLOT_BIT]),
    .enter_o(enter), .ctrl_o(ctrl_o), .case_o(own_case), .cnt_o(cnt)
  );

  bos_pins #(
    .CNT_W(CNT_W), .FS_HOLD(FS_HOLD), .SCLK_HOLD(SCLK_HOLD), .SDO_HOLD(SDO_HOLD)
  ) u_pins (
    .clk(clk), .rst(rst), .ctrl_i(ctrl_o), .case_i(own_case), .cnt_i(cnt),
    .dm_fs_i('{d: dm_fs_d, oe: dm_fs_oe}),
    .dm_sclk_i('{d: dm_sclk_d, oe: dm_sclk_oe}),
    .dm_sdo_i('{d: dm_sdo_d, oe: dm_sdo_oe}),
    .dm_tso_i('{d: dm_tso_d, oe: dm_tso_oe}),
    .fs_o(fs_p), .sclk_o(sclk_p), .sdo_o(sdo_p), .tso_o(tso_p)
  );

  // configuration register: the entry reload wins over a write
  always_ff @(posedge clk) begin
    if (rst || enter) cfg_r <= CFG_DEFAULT;
    else if (cfg_we)  cfg_r <= cfg_wdata;
  end

  assign cfg_q   = cfg_r;
  assign mute_o  = cfg_r[MUTE_BIT];
  assign fs_d    = fs_p.d;
  assign fs_oe   = fs_p.oe;
  assign sclk_d  = sclk_p.d;
  assign sclk_oe = sclk_p.oe;
  assign sdo_d   = sdo_p.d;
  assign sdo_oe  = sdo_p.oe;
  assign tso_d   = tso_p.d;
  assign tso_oe  = tso_p.oe;

  // R9: defaults, including mute, restored on control mode entry
  p_reload_r9: assert property (@(posedge clk) disable iff (rst)
    enter |=> (cfg_r == CFG_DEFAULT && mute_o == CFG_DEFAULT[MUTE_BIT]));
  // R1: control mode only follows a low synchronised pin
  p_ctrl_src_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_o) |-> $past(!dc_sync));
endmodule

// File: tb/sim_bos_mode_switch.sv
module sim_bos_mode_switch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dc = 1'b1;
  logic we = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0] dm = '0; // {fs_d,fs_oe,sclk_d,sclk_oe,sdo_d,sdo_oe,tso_d,tso_oe}
  logic fs_d, fs_oe, sclk_d, sclk_oe, sdo_d, sdo_oe, tso_d, tso_oe;
  logic [15:0] cfg;
  logic mute, ctrl;
  int tests = 0;
  int fails = 0;
  bit done = 0;
  localparam logic [15:0] DEF = 16'h0001;

  always #10 clk = ~clk; // 50 MHz

  bos_mode_switch u0 (
    .clk(clk), .rst(rst), .dc_i(dc), .cfg_we(we), .cfg_wdata(wdata),
    .dm_fs_d(dm[7]), .dm_fs_oe(dm[6]), .dm_sclk_d(dm[5]), .dm_sclk_oe(dm[4]),
    .dm_sdo_d(dm[3]), .dm_sdo_oe(dm[2]), .dm_tso_d(dm[1]), .dm_tso_oe(dm[0]),
    .fs_d(fs_d), .fs_oe(fs_oe), .sclk_d(sclk_d), .sclk_oe(sclk_oe),
    .sdo_d(sdo_d), .sdo_oe(sdo_oe), .tso_d(tso_d), .tso_oe(tso_oe),
    .cfg_q(cfg), .mute_o(mute), .ctrl_o(ctrl)
  );

  wire [7:0] pins = {fs_d, fs_oe, sclk_d, sclk_oe, sdo_d, sdo_oe, tso_d, tso_oe};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic t_reset;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 pins in reset", pins, 8'h00);
    chk("R11 cfg in reset", cfg, DEF);
    chk("R11 ctrl in reset", ctrl, 0);
    rst = 1'b0;
  endtask

  task automatic t_pass(input logic [7:0] pat);
    @(negedge clk); dm = pat;
    @(posedge clk); @(negedge clk);
    chk("R2 data mode pass-through", pins, pat);
  endtask

  task automatic leave_ctrl;
    @(negedge clk); dc = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 ctrl low after rise", ctrl, 0);
    @(posedge clk); @(negedge clk);
    chk("R12 pass-through resumes", pins, dm);
  endtask

  // run one schedule; mid_wr writes the opposite bits after period 0 (R10)
  task automatic t_case(input bit m, input bit s, input bit mid_wr);
    write_cfg({s, m, 14'h0002});
    chk("R9 plain write", cfg, {s, m, 14'h0002});
    @(negedge clk); dm = 8'hFF;
    @(negedge clk); dc = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 not yet in control", ctrl, 0);
    @(posedge clk); @(negedge clk);
    chk("R1 control entered", ctrl, 1);
    chk("R9 default reload", cfg, DEF);
    chk("R9 mute set", mute, 1);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] e;
      @(posedge clk); @(negedge clk);
      if (k == 0 && mid_wr) begin we = 1'b1; wdata = {~s, ~m, 14'h0000}; end
      if (k == 1 && mid_wr) begin
        we = 1'b0;
        chk("R10 write in control lands", cfg, {~s, ~m, 14'h0000});
      end
      e = 8'b0000_0001; // R8 tso driven low
      if (m && !s && k < 1) e[6] = 1'b1;          // R3 fs low
      if (m && !s && k < 3) e[5:4] = 2'b11;       // R4 sclk driven
      if (!m && !s && k < 1) e[2] = 1'b1;         // R6 sdo low
      if (m && !s)  chk($sformatf("R3/R4 master slot0 k=%0d%s", k, mid_wr ? " R10" : ""), pins, e);
      if (m && s)   chk($sformatf("R5 master slot1 k=%0d", k), pins, e);
      if (!m && !s) chk($sformatf("R6 slave slot0 k=%0d", k), pins, e);
      if (!m && s)  chk($sformatf("R7 slave slot1 k=%0d", k), pins, e);
      chk("R8 tso low", {tso_oe, tso_d}, 2'b10);
    end
    leave_ctrl();
  endtask

  task automatic t_entry_write;
    @(negedge clk); dc = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); we = 1'b1; wdata = 16'h5555;
    @(posedge clk); @(negedge clk); we = 1'b0;
    chk("R9 reload beats same-edge write", cfg, DEF);
    leave_ctrl();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass(8'b1011_0110);
    t_pass(8'b0100_1001);
    t_case(1'b1, 1'b0, 1'b0);
    t_case(1'b1, 1'b1, 1'b0);
    t_case(1'b0, 1'b0, 1'b0);
    t_case(1'b0, 1'b1, 1'b0);
    t_case(1'b1, 1'b0, 1'b1);
    t_entry_write();
    t_pass(8'b1100_0011);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule